// File: doc/BRIEF.md
# UART receive FIFO status controller

This block sits between the receive shift register of a UART and its register interface. Each completed character arrives as a one-cycle strobe carrying the data byte and a parity-error flag. The block stores these in a first-in first-out queue with the flag kept beside each byte. It shows the oldest character to the register read path and produces the line-status parity and overrun flags. It also produces two interrupts: one when enough data is waiting, and one when data sits unread for too long. It drives an active-low DMA request line as well.

With queueing enabled, the block holds up to `DEPTH` characters (16 by default). The data-available interrupt follows a selectable fill level. A character-time tick drives a four-character inactivity timer. With queueing disabled, the block acts as a single holding register, and a new character overwrites an unread one. Software reads the receive buffer through `rbr_rd` and the line status through `lsr_rd`. A one-cycle `fifo_clr` empties the queue.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: With `fifo_en`=1, characters come out of `rbr_data` in arrival order, up to DEPTH (16) are held, and `data_ready` is 1 exactly when at least one is held; a read of the buffer removes the head.
- R2: With `fifo_en`=1, the data-available condition is fill level >= trigger, with `trig_sel` 0,1,2,3 selecting 1, 4, 8, 14 characters (1, DEPTH/4, DEPTH/2, DEPTH-2).
- R3: `rda_irq` and `tmo_irq` are both forced low while `rda_ie`=0; a pending time-out becomes visible when `rda_ie` returns to 1.
- R4: `perr_flag` rises only when a character whose parity flag is set becomes the head of the queue, never while it waits behind another.
- R5: `perr_flag` is cleared by a line-status read, and replaced by the new head's parity flag whenever a new character is loaded into the head position.
- R6: With `fifo_en`=1, a character completing while DEPTH characters are held and no read occurs sets `ovr_flag` on the next cycle, leaves the queue untouched and discards the new character; a read in the same cycle makes room and accepts it.
- R7: `ovr_flag` is cleared by a line-status read (a simultaneous new overrun wins).
- R8: With `fifo_en`=1 and the queue non-empty, the fourth `char_tick` with no queue write or read since the last activity raises `tmo_irq` (when enabled).
- R9: Any write to or read from the queue restarts the time-out count; a buffer read clears a pending time-out.
- R10: Unless both `dma_mode` and `fifo_en` are 1, `rx_rdy_n` is 0 while any character is held and 1 when none is.
- R11: With `dma_mode`=1 and `fifo_en`=1, `rx_rdy_n` goes low when the fill level reaches the trigger or a time-out is pending, stays low until the queue is empty, then goes high.
- R12: With `fifo_en`=0 the block holds one character; `rda_irq` follows `data_ready`; a second character before a read overwrites the first and sets `ovr_flag`.
- R13: A `fifo_clr` pulse empties the queue, ignores a character arriving in the same cycle, and clears any pending time-out and data-available condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_done | input | 1 | One-cycle strobe: a character has been assembled |
| char_data | input | 8 | Data of the assembled character |
| char_perr | input | 1 | Parity error of the assembled character |
| char_tick | input | 1 | One-cycle pulse per character time |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| fifo_en | input | 1 | Queue mode enable |
| fifo_clr | input | 1 | Empty the queue |
| trig_sel | input | 2 | Trigger level select |
| dma_mode | input | 1 | DMA request mode select |
| rda_ie | input | 1 | Received-data interrupt enable |
| rbr_data | output | 8 | Head character (0 when empty) |
| data_ready | output | 1 | At least one character held |
| perr_flag | output | 1 | Parity error status |
| ovr_flag | output | 1 | Overrun status |
| rda_irq | output | 1 | Data-available interrupt |
| tmo_irq | output | 1 | Character time-out interrupt |
| rx_rdy_n | output | 1 | Active-low receive DMA request |

## Verification
The bench fills the queue to exactly sixteen and sends one more character. A design that overwrote stored data, or counted the dropped character, would return a seventeenth byte or a corrupted one when the queue is drained. It queues a bad-parity character behind a good one, which catches a flag raised at arrival rather than at the head, and then lets a clean character take the head to show the flag is replaced. The timer is driven with three ticks, then a fourth, and with activity placed between ticks, so an off-by-one count or a missing restart shows up as an early or absent time-out. The DMA line in the multi-character mode is drained from the trigger down to one character, which exposes a request that drops as soon as the fill level falls below the trigger.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

  typedef enum logic {
    RDY_SINGLE = 1'b0,
    RDY_MULTI  = 1'b1
  } rdy_mode_e;

  // Fill level for a trigger selection, scaled from the queue depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    int unsigned lvl;
    case (sel)
      2'd0:    lvl = 1;
      2'd1:    lvl = depth / 4;
      2'd2:    lvl = depth / 2;
      default: lvl = depth - 2;
    endcase
    return lvl;
  endfunction

  // Next slot of a circular index.
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/uart_rxf_store.sv
module uart_rxf_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned EW = DATA_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          replace,
  input  logic [EW-1:0] in_entry,
  output logic [EW-1:0] head_entry,
  output logic [CW-1:0] count,
  output logic          head_load,
  output logic          next_head_perr
);
  import uart_rxf_pkg::*;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW-1:0] rd_nxt, wr_nxt;
  logic [EW-1:0] second_entry;
  logic          empty, single;

  assign rd_nxt       = AW'(ring_next(int'(rd_ptr), DEPTH));
  assign wr_nxt       = AW'(ring_next(int'(wr_ptr), DEPTH));
  assign empty        = (count == '0);
  assign single       = (count == CW'(1));
  assign head_entry   = empty ? '0 : mem[rd_ptr];
  assign second_entry = mem[rd_nxt];

  // A character enters the head position when it lands in an empty queue,
  // when it overwrites the single holding slot, or when a read exposes the
  // entry behind the current head.
  always_comb begin
    head_load      = 1'b0;
    next_head_perr = 1'b0;
    if (!clr) begin
      if (replace || (push && (empty || (pop && single)))) begin
        head_load      = 1'b1;
        next_head_perr = in_entry[EW-1];
      end else if (pop && !single) begin
        head_load      = 1'b1;
        next_head_perr = second_entry[EW-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push)
        mem[wr_ptr] <= in_entry;
      else if (replace)
        mem[rd_ptr] <= in_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/uart_rxf_timeout.sv
module uart_rxf_timeout #(
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned TW = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clr,
  input  logic tick,
  input  logic activity,
  input  logic nonempty,
  input  logic rd,
  output logic pend,
  output logic fire
);
  logic [TW-1:0] idle_cnt;
  logic          hold_zero;

  assign hold_zero = clr || !enable || !nonempty || activity;
  assign fire      = !hold_zero && tick && !pend
                     && (idle_cnt == TW'(TMO_CHARS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      pend     <= 1'b0;
    end else begin
      if (hold_zero)
        idle_cnt <= '0;
      else if (tick && idle_cnt != TW'(TMO_CHARS))
        idle_cnt <= idle_cnt + TW'(1);

      if (clr || rd || !enable)
        pend <= 1'b0;
      else if (fire)
        pend <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rxf_status.sv
module uart_rxf_status
  import uart_rxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      head_load,
  input  logic      new_perr,
  input  logic      lsr_rd,
  input  logic      ovr_evt,
  input  rdy_mode_e rdy_mode,
  input  logic      lvl_hit,
  input  logic      tmo_pend,
  input  logic      nonempty,
  output logic      perr_flag,
  output logic      ovr_flag,
  output logic      rx_rdy_n
);
  logic multi_hold, multi_rdy;

  always_comb begin
    if (rdy_mode == RDY_MULTI) begin
      multi_rdy = lvl_hit || tmo_pend || (multi_hold && nonempty);
      rx_rdy_n  = !multi_rdy;
    end else begin
      multi_rdy = 1'b0;
      rx_rdy_n  = !nonempty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_flag  <= 1'b0;
      ovr_flag   <= 1'b0;
      multi_hold <= 1'b0;
    end else begin
      if (head_load)
        perr_flag <= new_perr;
      else if (lsr_rd)
        perr_flag <= 1'b0;

      if (ovr_evt)
        ovr_flag <= 1'b1;
      else if (lsr_rd)
        ovr_flag <= 1'b0;

      multi_hold <= multi_rdy;
    end
  end

endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TMO_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_tick,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  input  logic              fifo_en,
  input  logic              fifo_clr,
  input  logic [1:0]        trig_sel,
  input  logic              dma_mode,
  input  logic              rda_ie,
  output logic [DATA_W-1:0] rbr_data,
  output logic              data_ready,
  output logic              perr_flag,
  output logic              ovr_flag,
  output logic              rda_irq,
  output logic              tmo_irq,
  output logic              rx_rdy_n
);
  import uart_rxf_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DATA_W + 1;

  // Named internal events, also observed by the bound checker.
  logic [CW-1:0] count;
  logic [CW-1:0] trig_cnt;
  logic [EW-1:0] head_entry;
  logic          head_perr;
  logic          cap_full, push_ok, pop_ok, ovr_evt, replace;
  logic          head_load, next_head_perr;
  logic          activity, lvl_hit, tmo_pend, tmo_fire;
  rdy_mode_e     rdy_mode;

  assign trig_cnt = CW'(trig_level(trig_sel, DEPTH));
  assign pop_ok   = rbr_rd && data_ready && !fifo_clr;
  assign cap_full = (fifo_en ? (count >= CW'(DEPTH)) : data_ready) && !pop_ok;
  assign push_ok  = char_done && !fifo_clr && !cap_full;
  assign ovr_evt  = char_done && !fifo_clr && cap_full;
  assign replace  = ovr_evt && !fifo_en;
  assign activity = push_ok || pop_ok || replace;

  uart_rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (fifo_clr),
    .push           (push_ok),
    .pop            (pop_ok),
    .replace        (replace),
    .in_entry       ({char_perr, char_data}),
    .head_entry     (head_entry),
    .count          (count),
    .head_load      (head_load),
    .next_head_perr (next_head_perr)
  );

  assign data_ready = (count != '0);
  assign rbr_data   = head_entry[DATA_W-1:0];
  assign head_perr  = head_entry[EW-1];
  assign lvl_hit    = fifo_en ? (count >= trig_cnt) : data_ready;

  uart_rxf_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (fifo_en),
    .clr      (fifo_clr),
    .tick     (char_tick),
    .activity (activity),
    .nonempty (data_ready),
    .rd       (pop_ok),
    .pend     (tmo_pend),
    .fire     (tmo_fire)
  );

  assign rdy_mode = (dma_mode && fifo_en) ? RDY_MULTI : RDY_SINGLE;

  uart_rxf_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_load (head_load),
    .new_perr  (next_head_perr),
    .lsr_rd    (lsr_rd),
    .ovr_evt   (ovr_evt),
    .rdy_mode  (rdy_mode),
    .lvl_hit   (lvl_hit),
    .tmo_pend  (tmo_pend),
    .nonempty  (data_ready),
    .perr_flag (perr_flag),
    .ovr_flag  (ovr_flag),
    .rx_rdy_n  (rx_rdy_n)
  );

  assign rda_irq = rda_ie && lvl_hit;
  assign tmo_irq = rda_ie && tmo_pend;

endmodule

// File: rtl/uart_rxf_chk.sv
module uart_rxf_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          fifo_clr,
  input logic          dma_mode,
  input logic          lsr_rd,
  input logic          rda_irq,
  input logic          tmo_irq,
  input logic          data_ready,
  input logic          rx_rdy_n,
  input logic          perr_flag,
  input logic          ovr_flag,
  input logic          ovr_evt,
  input logic          head_perr,
  input logic [CW-1:0] count
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1

  AST_RDA_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rda_irq |-> data_ready); // R2

  AST_PERR_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_flag) |-> (data_ready && head_perr)); // R4

  AST_OVR_KEEPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && fifo_en) |=> (count == $past(count))); // R6

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_flag); // R6

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !ovr_flag); // R7

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> data_ready); // R8

  AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_mode && fifo_en) |-> (rx_rdy_n == !data_ready)); // R10

  AST_DMA_MULTI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> rx_rdy_n); // R11

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!data_ready && !tmo_irq)); // R13

endmodule

bind uart_rx_fifo_ctl uart_rxf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .fifo_clr   (fifo_clr),
  .dma_mode   (dma_mode),
  .lsr_rd     (lsr_rd),
  .rda_irq    (rda_irq),
  .tmo_irq    (tmo_irq),
  .data_ready (data_ready),
  .rx_rdy_n   (rx_rdy_n),
  .perr_flag  (perr_flag),
  .ovr_flag   (ovr_flag),
  .ovr_evt    (ovr_evt),
  .head_perr  (head_perr),
  .count      (count)
);

// File: tb/tb_uart_rx_fifo_ctl.sv
module tb_uart_rx_fifo_ctl;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_done = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_perr = 1'b0;
  logic       char_tick = 1'b0;
  logic       rbr_rd = 1'b0;
  logic       lsr_rd = 1'b0;
  logic       fifo_en = 1'b0;
  logic       fifo_clr = 1'b0;
  logic [1:0] trig_sel = '0;
  logic       dma_mode = 1'b0;
  logic       rda_ie = 1'b0;
  logic [7:0] rbr_data;
  logic       data_ready, perr_flag, ovr_flag, rda_irq, tmo_irq, rx_rdy_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] exp_q [$];

  always #4 clk = ~clk;

  uart_rx_fifo_ctl dut (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
    .char_perr(char_perr), .char_tick(char_tick), .rbr_rd(rbr_rd),
    .lsr_rd(lsr_rd), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
    .trig_sel(trig_sel), .dma_mode(dma_mode), .rda_ie(rda_ie),
    .rbr_data(rbr_data), .data_ready(data_ready), .perr_flag(perr_flag),
    .ovr_flag(ovr_flag), .rda_irq(rda_irq), .tmo_irq(tmo_irq),
    .rx_rdy_n(rx_rdy_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // Expected trigger level, restated from the requirement table (R2).
  function automatic int exp_trig(input int sel);
    int t [4] = '{1, 4, 8, 14};
    return t[sel];
  endfunction

  // Driver: one character; the model decides acceptance and queues it.
  task automatic send(input logic [7:0] d, input logic p);
    char_done = 1'b1; char_data = d; char_perr = p;
    if (fifo_en) begin
      if (exp_q.size() < DEPTH || rbr_rd) exp_q.push_back({p, d});
    end else begin
      if (exp_q.size() == 0) exp_q.push_back({p, d});
      else exp_q[0] = {p, d};
    end
    cyc();
    char_done = 1'b0;
  endtask

  task automatic rd();
    rbr_rd = 1'b1; cyc(); rbr_rd = 1'b0;
  endtask

  task automatic send_rd(input logic [7:0] d);
    rbr_rd = 1'b1;
    send(d, 1'b0);
    rbr_rd = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1; cyc(); char_tick = 1'b0;
  endtask

  task automatic lsr();
    lsr_rd = 1'b1; cyc(); lsr_rd = 1'b0;
  endtask

  task automatic setup(input logic fen, input logic dma, input logic [1:0] sel, input logic ie);
    fifo_en = fen; dma_mode = dma; trig_sel = sel; rda_ie = ie;
    fifo_clr = 1'b1; cyc(); fifo_clr = 1'b0;
    exp_q.delete();
    lsr();
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) rd();
    chk(req, "empty after drain", data_ready, 0);
  endtask

  // Monitor: compares every buffer read against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rbr_rd && !fifo_clr) begin
      if (exp_q.size() == 0) begin
        chk("R1", "data_ready on empty read", data_ready, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R1", "head data", rbr_data, e[7:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1", "reset data_ready", data_ready, 0);
    chk("R10", "reset rx_rdy_n", rx_rdy_n, 1);
    chk("R5", "reset perr", perr_flag, 0);
    chk("R7", "reset ovr", ovr_flag, 0);

    // R2 trigger levels, boundary below and at each level
    for (int s = 0; s < 4; s++) begin
      setup(1'b1, 1'b0, 2'(s), 1'b1);
      for (int i = 0; i < exp_trig(s) - 1; i++) send(8'(16 * s + i), 1'b0);
      chk("R2", $sformatf("rda below trig sel %0d", s), rda_irq, 0);
      send(8'hA0 + 8'(s), 1'b0);
      chk("R2", $sformatf("rda at trig sel %0d", s), rda_irq, 1);
      drain("R1");
      chk("R2", "rda cleared when empty", rda_irq, 0);
    end

    // R4 / R5 parity only at head
    setup(1'b1, 1'b0, 2'd0, 1'b1);
    send(8'h11, 1'b0);
    send(8'h22, 1'b1);
    chk("R4", "perr while bad char waits", perr_flag, 0);
    rd();
    chk("R4", "perr once bad char is head", perr_flag, 1);
    lsr();
    chk("R5", "perr cleared by status read", perr_flag, 0);
    drain("R1");
    send(8'h33, 1'b1);
    chk("R4", "perr on bad char into empty", perr_flag, 1);
    send(8'h44, 1'b0);
    rd();
    chk("R5", "perr replaced by clean head", perr_flag, 0);
    drain("R1");

    // R6 / R7 overrun keeps the FIFO
    setup(1'b1, 1'b0, 2'd3, 1'b1);
    for (int i = 0; i < DEPTH; i++) send(8'h50 + 8'(i), 1'b0);
    chk("R6", "no ovr at exactly full", ovr_flag, 0);
    send(8'hEE, 1'b0);
    chk("R6", "ovr after extra char", ovr_flag, 1);
    send_rd(8'h77);
    chk("R6", "read+write when full accepted", ovr_flag, 1);
    lsr();
    chk("R7", "ovr cleared by status read", ovr_flag, 0);
    drain("R6");

    // R8 / R9 time-out
    setup(1'b1, 1'b0, 2'd1, 1'b1);
    send(8'h61, 1'b0);
    repeat (3) tick();
    chk("R8", "no timeout after 3 ticks", tmo_irq, 0);
    tick();
    chk("R8", "timeout after 4 ticks", tmo_irq, 1);
    rd();
    chk("R9", "timeout cleared by read", tmo_irq, 0);
    send(8'h62, 1'b0);
    repeat (3) tick();
    send(8'h63, 1'b0);
    repeat (3) tick();
    chk("R9", "activity restarted count", tmo_irq, 0);
    tick();
    chk("R9", "timeout after restart", tmo_irq, 1);
    drain("R9");

    // R3 masking
    setup(1'b1, 1'b0, 2'd0, 1'b0);
    send(8'h71, 1'b0);
    chk("R3", "rda masked", rda_irq, 0);
    repeat (4) tick();
    chk("R3", "timeout masked", tmo_irq, 0);
    rda_ie = 1'b1; #1;
    chk("R3", "pending timeout visible on enable", tmo_irq, 1);
    drain("R3");

    // R13 clear
    setup(1'b1, 1'b0, 2'd0, 1'b1);
    send(8'h81, 1'b0);
    send(8'h82, 1'b0);
    repeat (4) tick();
    fifo_clr = 1'b1; char_done = 1'b1; char_data = 8'h83;
    cyc();
    fifo_clr = 1'b0; char_done = 1'b0;
    exp_q.delete();
    chk("R13", "clear empties", data_ready, 0);
    chk("R13", "clear drops timeout", tmo_irq, 0);
    chk("R13", "clear drops rda", rda_irq, 0);

    // R10 single-character DMA mode, also with FIFO disabled
    setup(1'b1, 1'b0, 2'd2, 1'b1);
    send(8'h91, 1'b0);
    chk("R10", "rdy low with one char", rx_rdy_n, 0);
    drain("R10");
    chk("R10", "rdy high when empty", rx_rdy_n, 1);
    setup(1'b0, 1'b1, 2'd2, 1'b1);
    send(8'h92, 1'b0);
    chk("R10", "rdy low, FIFO off, dma 1", rx_rdy_n, 0);

    // R12 non-FIFO holding register
    chk("R12", "rda with one char", rda_irq, 1);
    send(8'h93, 1'b0);
    chk("R12", "overwrite sets ovr", ovr_flag, 1);
    rd();
    chk("R12", "single char held", data_ready, 0);

    // R11 multi-character DMA mode
    setup(1'b1, 1'b1, 2'd1, 1'b1);
    send(8'hB0, 1'b0);
    chk("R11", "rdy high below trig", rx_rdy_n, 1);
    for (int i = 1; i < 4; i++) send(8'hB0 + 8'(i), 1'b0);
    chk("R11", "rdy low at trig", rx_rdy_n, 0);
    repeat (3) rd();
    chk("R11", "rdy held low with one left", rx_rdy_n, 0);
    rd();
    chk("R11", "rdy high when empty", rx_rdy_n, 1);
    send(8'hC0, 1'b0);
    repeat (4) tick();
    chk("R11", "rdy low on timeout", rx_rdy_n, 0);
    drain("R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule